// File: doc/BRIEF.md
# Iterative Integer Multiply-Divide Engine

This block computes integer products and quotients for a processor pipeline without holding that pipeline up while it works. The issuer hands it two operands and a function code for one cycle. From then on the engine runs by itself. It keeps two result registers: HI holds the upper half of a product or the remainder of a division, and LO holds the lower half of a product or the quotient.

The issuer keeps going with other work after the start. When it later asks for HI or LO while an operation is still running, the engine raises a stall until the result is written. Both multiply and divide work on operand magnitudes, one bit per cycle. A final cycle applies the sign correction and writes HI and LO. Issuing a new operation while one is running drops the old one and starts over with the new operands.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, busy_o is 0, stall_o is 0, and both HI and LO read as 0.
- R2: On a clock edge where start_i is 1, function code 0x18 starts a signed multiply, 0x19 an unsigned multiply, 0x1A a signed divide and 0x1B an unsigned divide. With any other code, start_i is ignored: busy_o stays 0 and HI and LO keep their values.
- R3: A multiply writes the upper WIDTH bits of the 2*WIDTH-bit product to HI and the lower WIDTH bits to LO. The signed and unsigned forms differ: for 32 bits, 0xFFFFFFFF times itself gives HI=0, LO=1 when signed and HI=0xFFFFFFFE, LO=1 when unsigned.
- R4: A divide writes the quotient, truncated toward zero, to LO and the remainder to HI. In the signed form the remainder takes the sign of the dividend.
- R5: busy_o is 1 for exactly WIDTH+1 cycles after the edge that accepts a start. HI and LO change only on the last of those edges, and the new values can be read once busy_o is 0.
- R6: While rd_req_i is 1, read code 0x10 puts HI on rd_data_o and read code 0x12 puts LO on rd_data_o. Any other read code returns 0 and never stalls.
- R7: stall_o is 1 exactly when rd_req_i is 1 with read code 0x10 or 0x12 while busy_o is 1. A start never raises stall_o.
- R8: A start accepted while busy_o is 1 abandons the running operation. The results then come from the new operands only, and the full WIDTH+1 cycle latency counts again from the new start.
- R9: A divide by zero finishes with the same WIDTH+1 cycle latency as any other divide. The values it leaves in HI and LO are fixed by the operands but not specified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Issue pulse for the operation in func_i |
| func_i | input | 6 | Operation code (0x18, 0x19, 0x1A, 0x1B) |
| src_a_i | input | WIDTH | Multiplicand or dividend |
| src_b_i | input | WIDTH | Multiplier or divisor |
| rd_req_i | input | 1 | Result read request |
| rd_func_i | input | 6 | Read code: 0x10 for HI, 0x12 for LO |
| rd_data_o | output | WIDTH | Selected result register |
| busy_o | output | 1 | Operation in flight |
| stall_o | output | 1 | Hold the requester: the result it reads is not ready |

## Verification
Some properties are checked on every cycle:
- an accepted start raises busy in the next cycle, and a bad code leaves the engine idle;
- busy always falls exactly WIDTH+1 edges after the last accepted start;
- HI and LO do not move while the iteration runs;
- the running remainder of a divide stays below a non-zero divisor.

The numeric results can only be shown by the bench's scenarios:
- a full sweep of all operand pairs and all four functions on a 4-bit instance, compared against arithmetic done in the bench;
- 32-bit corner cases;
- a restart in mid-operation;
- the stall response to reads issued early;
- completion of a divide by zero.

// File: rtl/muldiv_pkg.sv
// Shared codes and state type for the multiply-divide engine.
// Assumes 6-bit function codes shared with the issuing pipeline's decoder.
package muldiv_pkg;
    localparam logic [5:0] FN_MULS = 6'h18;
    localparam logic [5:0] FN_MULU = 6'h19;
    localparam logic [5:0] FN_DIVS = 6'h1A;
    localparam logic [5:0] FN_DIVU = 6'h1B;
    localparam logic [5:0] FN_GETH = 6'h10;
    localparam logic [5:0] FN_GETL = 6'h12;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } md_state_t;
endpackage

// File: rtl/muldiv_magnitude.sv
// Turns an operand into its magnitude and a sign flag.
// Assumes two's complement; with signed_en low the operand passes unchanged.
module muldiv_magnitude #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic             signed_en_i,
    output logic [WIDTH-1:0] mag_o,
    output logic             neg_o
);
    // Magnitude and sign selection
    always_comb begin
        neg_o = signed_en_i && val_i[WIDTH-1];
        mag_o = neg_o ? (~val_i + 1'b1) : val_i;
    end
endmodule

// File: rtl/muldiv_mul_step.sv
// One shift-add multiply step on an upper/lower accumulator pair.
// Assumes the lower half starts out holding the multiplier magnitude.
module muldiv_mul_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] upper_i,
    input  logic [WIDTH-1:0] lower_i,
    input  logic [WIDTH-1:0] mcand_i,
    output logic [WIDTH-1:0] upper_o,
    output logic [WIDTH-1:0] lower_o
);
    logic [WIDTH:0] sum;

    // Conditional add, then shift the whole pair right by one bit
    always_comb begin
        sum     = {1'b0, upper_i} + (lower_i[0] ? {1'b0, mcand_i} : '0);
        upper_o = sum[WIDTH:1];
        lower_o = {sum[0], lower_i[WIDTH-1:1]};
    end
endmodule

// File: rtl/muldiv_div_step.sv
// One restoring-division step: shift one dividend bit in, trial-subtract.
// Assumes rem_i < dvsr_i whenever dvsr_i is non-zero.
module muldiv_div_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] rem_i,
    input  logic [WIDTH-1:0] quo_i,
    input  logic [WIDTH-1:0] dvsr_i,
    output logic [WIDTH-1:0] rem_o,
    output logic [WIDTH-1:0] quo_o
);
    logic [WIDTH:0] shifted;
    logic           fits;

    // Trial subtraction and selection of the quotient bit
    always_comb begin
        shifted = {rem_i, quo_i[WIDTH-1]};
        fits    = shifted >= {1'b0, dvsr_i};
        rem_o   = fits ? (shifted[WIDTH-1:0] - dvsr_i) : shifted[WIDTH-1:0];
        quo_o   = {quo_i[WIDTH-2:0], fits};
    end
endmodule

// File: rtl/muldiv_unit.sv
// Multiply-divide engine with HI/LO result registers and an interlocked read.
// A start takes one cycle; the engine then runs WIDTH steps and one
// sign-correction cycle. A new start always wins over a running operation.
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [5:0]       func_i,
    input  logic [WIDTH-1:0] src_a_i,
    input  logic [WIDTH-1:0] src_b_i,
    input  logic             rd_req_i,
    input  logic [5:0]       rd_func_i,
    output logic [WIDTH-1:0] rd_data_o,
    output logic             busy_o,
    output logic             stall_o
);
    localparam int CNT_W  = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam int AGE_W  = $clog2(WIDTH + 2);
    localparam int PROD_W = 2 * WIDTH;

    md_state_t        state_q;
    logic [CNT_W-1:0] step_q;
    logic [WIDTH-1:0] acc_hi_q, acc_lo_q, opnd_b_q;
    logic             is_div_q, neg_res_q, neg_rem_q;
    logic [WIDTH-1:0] hi_q, lo_q;

    logic             code_ok, accept, sign_req, div_req;
    logic [WIDTH-1:0] mag_a, mag_b;
    logic             neg_a, neg_b;
    logic [WIDTH-1:0] mul_hi, mul_lo, div_hi, div_lo;
    logic [PROD_W-1:0] prod_fix;
    logic             rd_hit;

    // Decode of the issued function code
    always_comb begin
        code_ok  = (func_i == FN_MULS) || (func_i == FN_MULU) ||
                   (func_i == FN_DIVS) || (func_i == FN_DIVU);
        accept   = start_i && code_ok;
        sign_req = (func_i == FN_MULS) || (func_i == FN_DIVS);
        div_req  = (func_i == FN_DIVS) || (func_i == FN_DIVU);
    end

    muldiv_magnitude #(.WIDTH(WIDTH)) u_mag_a (
        .val_i(src_a_i), .signed_en_i(sign_req), .mag_o(mag_a), .neg_o(neg_a)
    );
    muldiv_magnitude #(.WIDTH(WIDTH)) u_mag_b (
        .val_i(src_b_i), .signed_en_i(sign_req), .mag_o(mag_b), .neg_o(neg_b)
    );

    muldiv_mul_step #(.WIDTH(WIDTH)) u_mul (
        .upper_i(acc_hi_q), .lower_i(acc_lo_q), .mcand_i(opnd_b_q),
        .upper_o(mul_hi), .lower_o(mul_lo)
    );
    muldiv_div_step #(.WIDTH(WIDTH)) u_div (
        .rem_i(acc_hi_q), .quo_i(acc_lo_q), .dvsr_i(opnd_b_q),
        .rem_o(div_hi), .quo_o(div_lo)
    );

    // Signed correction of the full product in the final cycle
    always_comb begin
        prod_fix = neg_res_q ? (~{acc_hi_q, acc_lo_q} + 1'b1) : {acc_hi_q, acc_lo_q};
    end

    // Sequencer, iteration registers and HI/LO result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            step_q    <= '0;
            acc_hi_q  <= '0;
            acc_lo_q  <= '0;
            opnd_b_q  <= '0;
            is_div_q  <= 1'b0;
            neg_res_q <= 1'b0;
            neg_rem_q <= 1'b0;
            hi_q      <= '0;
            lo_q      <= '0;
        end else if (accept) begin
            state_q   <= ST_RUN;
            step_q    <= '0;
            acc_hi_q  <= '0;
            acc_lo_q  <= mag_a;
            opnd_b_q  <= mag_b;
            is_div_q  <= div_req;
            neg_res_q <= neg_a ^ neg_b;
            neg_rem_q <= neg_a;
        end else begin
            case (state_q)
                ST_RUN: begin
                    acc_hi_q <= is_div_q ? div_hi : mul_hi;
                    acc_lo_q <= is_div_q ? div_lo : mul_lo;
                    step_q   <= step_q + 1'b1;
                    if (step_q == CNT_W'(WIDTH - 1)) begin
                        state_q <= ST_FIX;
                    end
                end
                ST_FIX: begin
                    if (is_div_q) begin
                        hi_q <= neg_rem_q ? (~acc_hi_q + 1'b1) : acc_hi_q;
                        lo_q <= neg_res_q ? (~acc_lo_q + 1'b1) : acc_lo_q;
                    end else begin
                        hi_q <= prod_fix[PROD_W-1:WIDTH];
                        lo_q <= prod_fix[WIDTH-1:0];
                    end
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Result read port and interlock
    always_comb begin
        busy_o = (state_q != ST_IDLE);
        rd_hit = (rd_func_i == FN_GETH) || (rd_func_i == FN_GETL);
        case (rd_func_i)
            FN_GETH: rd_data_o = hi_q;
            FN_GETL: rd_data_o = lo_q;
            default: rd_data_o = '0;
        endcase
        stall_o = rd_req_i && rd_hit && busy_o;
    end

    // Cycles since the last accepted start, kept only for the latency check
    logic [AGE_W-1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (accept) begin
            age_q <= '0;
        end else if (busy_o) begin
            age_q <= age_q + 1'b1;
        end
    end

    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_o);                                          // R2
    AST_BAD_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !code_ok && !busy_o) |=> !busy_o);               // R2
    AST_LATENCY_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (age_q == AGE_W'(WIDTH + 1)));             // R5
    AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> $stable({hi_q, lo_q}));              // R5
    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (step_q <= CNT_W'(WIDTH - 1)));      // R5
    AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && is_div_q && opnd_b_q != '0) |-> (acc_hi_q < opnd_b_q)); // R4
endmodule

// File: tb/muldiv_unit_test.sv
`timescale 1ns/1ps
module muldiv_unit_test;
    localparam int NW = 4;
    localparam int WW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;

    // narrow instance (exhaustive sweep)
    logic          n_start = 0, n_req = 0;
    logic [5:0]    n_func = 0, n_rfunc = 0;
    logic [NW-1:0] n_a = 0, n_b = 0, n_data;
    logic          n_busy, n_stall;

    muldiv_unit #(.WIDTH(NW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(n_start), .func_i(n_func),
        .src_a_i(n_a), .src_b_i(n_b), .rd_req_i(n_req), .rd_func_i(n_rfunc),
        .rd_data_o(n_data), .busy_o(n_busy), .stall_o(n_stall)
    );

    // wide instance (directed corners)
    logic          w_start = 0, w_req = 0;
    logic [5:0]    w_func = 0, w_rfunc = 0;
    logic [WW-1:0] w_a = 0, w_b = 0, w_data;
    logic          w_busy, w_stall;

    muldiv_unit #(.WIDTH(WW)) uut_wide (
        .clk(clk), .rst_n(rst_n), .start_i(w_start), .func_i(w_func),
        .src_a_i(w_a), .src_b_i(w_b), .rd_req_i(w_req), .rd_func_i(w_rfunc),
        .rd_data_o(w_data), .busy_o(w_busy), .stall_o(w_stall)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Arithmetic model of HI/LO for width w
    task automatic model(input int w, input logic [5:0] f, input logic [31:0] a,
                         input logic [31:0] b, output logic [31:0] hi, output logic [31:0] lo);
        logic [63:0] ta, tb, ua, ub, mask, p, q, r;
        longint sa, sb;
        ta = 64'(a) << (64 - w);
        tb = 64'(b) << (64 - w);
        sa = $signed(ta) >>> (64 - w);
        sb = $signed(tb) >>> (64 - w);
        ua = 64'(a);
        ub = 64'(b);
        mask = (64'd1 << w) - 64'd1;
        p = '0; q = '0; r = '0;
        case (f)
            6'h18: p = 64'(sa * sb);
            6'h19: p = ua * ub;
            6'h1A: begin q = 64'(sa / sb); r = 64'(sa % sb); end
            default: begin q = ua / ub; r = ua % ub; end
        endcase
        if (f == 6'h18 || f == 6'h19) begin
            hi = 32'((p >> w) & mask);
            lo = 32'(p & mask);
        end else begin
            hi = 32'(r & mask);
            lo = 32'(q & mask);
        end
    endtask

    task automatic n_op(input logic [5:0] f, input logic [NW-1:0] a, input logic [NW-1:0] b,
                        output int lat, output logic [NW-1:0] hi, output logic [NW-1:0] lo);
        n_func = f; n_a = a; n_b = b; n_start = 1'b1;
        @(negedge clk);
        n_start = 1'b0;
        lat = 0;
        while (n_busy && lat < 500) begin
            lat++;
            @(negedge clk);
        end
        n_req = 1'b1;
        n_rfunc = 6'h10; #1 hi = n_data;
        n_rfunc = 6'h12; #1 lo = n_data;
        n_req = 1'b0;
    endtask

    task automatic w_op(input logic [5:0] f, input logic [WW-1:0] a, input logic [WW-1:0] b,
                        output int lat, output logic [WW-1:0] hi, output logic [WW-1:0] lo);
        w_func = f; w_a = a; w_b = b; w_start = 1'b1;
        @(negedge clk);
        w_start = 1'b0;
        lat = 0;
        while (w_busy && lat < 500) begin
            lat++;
            @(negedge clk);
        end
        w_req = 1'b1;
        w_rfunc = 6'h10; #1 hi = w_data;
        w_rfunc = 6'h12; #1 lo = w_data;
        w_req = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int lat;
        logic [NW-1:0] nh, nl;
        logic [WW-1:0] wh, wl;
        logic [31:0] eh, el;
        logic [5:0] fcode;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy", 64'(w_busy), 64'd0);
        w_req = 1'b1; w_rfunc = 6'h10; #1;
        chk("R1 hi", 64'(w_data), 64'd0);
        chk("R1 stall", 64'(w_stall), 64'd0);
        w_rfunc = 6'h12; #1;
        chk("R1 lo", 64'(w_data), 64'd0);
        w_req = 1'b0;

        // R3 R4 R5 R9: exhaustive 4-bit sweep
        for (int fi = 0; fi < 4; fi++) begin
            fcode = 6'h18 + 6'(fi);
            for (int ai = 0; ai < 16; ai++) begin
                for (int bi = 0; bi < 16; bi++) begin
                    n_op(fcode, NW'(ai), NW'(bi), lat, nh, nl);
                    chk("R5 latency", 64'(lat), 64'(NW + 1));
                    if (fi >= 2 && bi == 0) begin
                        chk("R9 div0 done", 64'(n_busy), 64'd0);
                    end else begin
                        model(NW, fcode, 32'(ai), 32'(bi), eh, el);
                        chk(fi < 2 ? "R3 hi" : "R4 hi", 64'(nh), 64'(eh));
                        chk(fi < 2 ? "R3 lo" : "R4 lo", 64'(nl), 64'(el));
                    end
                end
            end
        end

        // R3: 32-bit signed vs unsigned of all-ones
        w_op(6'h18, 32'hFFFFFFFF, 32'hFFFFFFFF, lat, wh, wl);
        chk("R3 signed hi", 64'(wh), 64'h0);
        chk("R3 signed lo", 64'(wl), 64'h1);
        chk("R5 wide latency", 64'(lat), 64'(WW + 1));
        w_op(6'h19, 32'hFFFFFFFF, 32'hFFFFFFFF, lat, wh, wl);
        chk("R3 unsigned hi", 64'(wh), 64'hFFFFFFFE);
        chk("R3 unsigned lo", 64'(wl), 64'h1);
        w_op(6'h18, 32'h80000000, 32'h7FFFFFFF, lat, wh, wl);
        model(WW, 6'h18, 32'h80000000, 32'h7FFFFFFF, eh, el);
        chk("R3 extreme hi", 64'(wh), 64'(eh));
        chk("R3 extreme lo", 64'(wl), 64'(el));

        // R4: 32-bit divides
        w_op(6'h1A, 32'hFFFFFF9C, 32'd7, lat, wh, wl);   // -100 / 7
        chk("R4 sdiv rem", 64'(wh), 64'hFFFFFFFE);      // -2
        chk("R4 sdiv quo", 64'(wl), 64'hFFFFFFF2);      // -14
        w_op(6'h1B, 32'hFFFFFF9C, 32'd7, lat, wh, wl);
        model(WW, 6'h1B, 32'hFFFFFF9C, 32'd7, eh, el);
        chk("R4 udiv rem", 64'(wh), 64'(eh));
        chk("R4 udiv quo", 64'(wl), 64'(el));
        w_op(6'h1A, 32'd100, 32'hFFFFFFF9, lat, wh, wl); // 100 / -7
        chk("R4 sdiv rem pos", 64'(wh), 64'd2);
        chk("R4 sdiv quo neg", 64'(wl), 64'hFFFFFFF2);

        // R9: wide divide by zero completes
        w_op(6'h1B, 32'd12345, 32'd0, lat, wh, wl);
        chk("R9 div0 latency", 64'(lat), 64'(WW + 1));

        // R2: bad start code ignored, HI/LO kept
        w_op(6'h19, 32'd6, 32'd7, lat, wh, wl);
        w_func = 6'h20; w_a = 32'd99; w_b = 32'd99; w_start = 1'b1;
        @(negedge clk);
        w_start = 1'b0;
        chk("R2 bad code busy", 64'(w_busy), 64'd0);
        w_req = 1'b1; w_rfunc = 6'h12; #1;
        chk("R2 lo kept", 64'(w_data), 64'd42);
        w_rfunc = 6'h10; #1;
        chk("R2 hi kept", 64'(w_data), 64'd0);

        // R6: other read code gives 0 and no stall
        w_rfunc = 6'h11; #1;
        chk("R6 other code data", 64'(w_data), 64'd0);
        chk("R6 other code stall", 64'(w_stall), 64'd0);
        w_req = 1'b0;

        // R7: stall during busy, not on start
        w_func = 6'h18; w_a = 32'd3; w_b = 32'd5; w_start = 1'b1; #1;
        chk("R7 no stall on start", 64'(w_stall), 64'd0);
        @(negedge clk);
        w_start = 1'b0;
        w_req = 1'b1; w_rfunc = 6'h10; #1;
        chk("R7 stall hi", 64'(w_stall), 64'd1);
        w_rfunc = 6'h12; #1;
        chk("R7 stall lo", 64'(w_stall), 64'd1);
        w_rfunc = 6'h11; #1;
        chk("R7 stall other code", 64'(w_stall), 64'd0);
        w_req = 1'b0; #1;
        chk("R7 no request", 64'(w_stall), 64'd0);

        // R8: restart mid-operation
        repeat (4) @(negedge clk);
        w_op(6'h1B, 32'd100, 32'd7, lat, wh, wl);
        chk("R8 restart latency", 64'(lat), 64'(WW + 1));
        chk("R8 restart rem", 64'(wh), 64'd2);
        chk("R8 restart quo", 64'(wl), 64'd14);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule